// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects level-sensitive, active-high hardware interrupt lines and presents them to a small set of CPUs. Each line has one mask bit. Each line also has a software trigger bit, which is ORed with the line to form its raw pending state. Every interrupt number has a fixed target CPU: number `i` goes to CPU `i % NUM_CPU`. A CPU's interrupt output is high while that CPU has at least one pending, unmasked interrupt.

Each CPU has its own simple synchronous register port. A CPU services interrupts by reading its event register. The read returns the lowest-numbered pending, unmasked interrupt that targets that CPU. In the same clock edge, the read sets that interrupt's mask bit, so the same event is never delivered twice. After servicing, software clears the mask bit again. If the line is still high at that point, the interrupt is reported again.

Mask bits and software bits are changed through separate write-1-to-set and write-1-to-clear words, with 32 interrupts per word. Because the ports are independent, one CPU can read an event in the same cycle that another CPU writes a mask word.

Top module: `auto_mask_intc`

## Requirements
- R1: After reset, every mask bit reads 1, every software bit reads 0, `cpu_irq_o` is 0 and an event read returns 0.
- R2: A hardware line counts as pending only while its input is high. Once the line drops, an unmasked interrupt on that line is no longer reported.
- R3: Writing to soft-set (class 2) sets the software bit for each 1 in the data, and writing to soft-clear (class 3) clears it. A set software bit makes its interrupt pending even when the line is low.
- R4: Writing to mask-set (class 0) and mask-clear (class 1) sets or clears the mask bit for each 1 in the data, and 0 bits change nothing. A masked interrupt never appears in an event and never drives `cpu_irq_o`.
- R5: Interrupt `i` targets CPU `i % NUM_CPU`. Among the pending, unmasked interrupts for a CPU, an event read reports the one with the lowest number.
- R6: An event read that delivers interrupt `n` sets mask bit `n` at the same clock edge. A second read therefore does not return `n` again until its mask bit is cleared.
- R7: The event word carries the type in bits [31:28] (1 = hardware interrupt), `DIE_ID` in bits [27:24], zeros in bits [23:16] and the interrupt number in bits [15:0]. A read with nothing eligible returns 32'h0.
- R8: `cpu_irq_o[c]` is registered. It changes one clock edge after the line, mask or software state changes.
- R9: If CPU A reads its event register in the same cycle that another port writes mask-clear for the delivered interrupt, the interrupt ends up masked.
- R10: Address bits [7:4] select the register class and bits [3:0] select the word index. The classes are: 0 mask-set, 1 mask-clear, 2 soft-set, 3 soft-clear, 4 mask read, 5 soft read, 6 event read, 7 pending read (line OR soft). Read data appears on `bus_rdata_o` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | NUM_IRQ | Level hardware interrupt lines, active high |
| bus_req_i | input | NUM_CPU | Per-port access request |
| bus_we_i | input | NUM_CPU | Per-port write enable (0 = read) |
| bus_addr_i | input | NUM_CPU*8 | Per-port address, port c at [c*8 +: 8] |
| bus_wdata_i | input | NUM_CPU*32 | Per-port write data |
| bus_rdata_o | output | NUM_CPU*32 | Per-port read data, registered |
| cpu_irq_o | output | NUM_CPU | Per-CPU interrupt request, registered |

## Verification
Two functions can fall in the same cycle: the auto-mask from an event read on one port, and a mask-clear write from the other port for the very interrupt being delivered. The bench provokes this by raising both port requests on the same clock edge, one port reading and the other writing. It then judges the outcome in two ways: the delivered event word must be correct, and a later mask readback must show that interrupt still masked. The bench also checks two timing relations: the same-edge auto-mask during a plain event read, and the one-cycle lag of the interrupt output.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    RC_MSET  = 4'd0,
    RC_MCLR  = 4'd1,
    RC_SSET  = 4'd2,
    RC_SCLR  = 4'd3,
    RC_MASK  = 4'd4,
    RC_SOFT  = 4'd5,
    RC_EVENT = 4'd6,
    RC_PEND  = 4'd7
  } reg_class_e;

  typedef enum logic [3:0] {
    EV_NONE = 4'd0,
    EV_HW   = 4'd1
  } ev_kind_e;

  typedef struct packed {
    logic [3:0]  kind;
    logic [3:0]  die;
    logic [7:0]  rsvd;
    logic [15:0] num;
  } event_t;
endpackage

// File: rtl/icu_port_decode.sv
module icu_port_decode
  import icu_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_IRQ-1:0] mask_set_o,
  output logic [NUM_IRQ-1:0] mask_clr_o,
  output logic [NUM_IRQ-1:0] sw_set_o,
  output logic [NUM_IRQ-1:0] sw_clr_o,
  output logic               rd_en_o,
  output logic               ev_rd_o,
  output reg_class_e         rd_class_o,
  output logic [3:0]         rd_word_o
);
  localparam int unsigned NUM_WORDS = NUM_IRQ / DATA_W;

  reg_class_e cls;
  logic       wr;

  assign cls        = reg_class_e'(addr_i[7:4]);
  assign wr         = req_i & we_i;
  assign rd_en_o    = req_i & ~we_i;
  assign ev_rd_o    = rd_en_o && (cls == RC_EVENT);
  assign rd_class_o = cls;
  assign rd_word_o  = addr_i[3:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr && (addr_i[3:0] == 4'(w));
    assign mask_set_o[w*DATA_W +: DATA_W] = (hit && cls == RC_MSET) ? wdata_i : '0;
    assign mask_clr_o[w*DATA_W +: DATA_W] = (hit && cls == RC_MCLR) ? wdata_i : '0;
    assign sw_set_o[w*DATA_W +: DATA_W]   = (hit && cls == RC_SSET) ? wdata_i : '0;
    assign sw_clr_o[w*DATA_W +: DATA_W]   = (hit && cls == RC_SCLR) ? wdata_i : '0;
  end
endmodule

// File: rtl/icu_state.sv
module icu_state #(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] mask_set_i,
  input  logic [NUM_IRQ-1:0] mask_clr_i,
  input  logic [NUM_IRQ-1:0] auto_mask_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  output logic [NUM_IRQ-1:0] mask_q_o,
  output logic [NUM_IRQ-1:0] sw_q_o
);
  // auto-mask and set both override a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '1;
      sw_q_o   <= '0;
    end else begin
      mask_q_o <= (mask_q_o & ~mask_clr_i) | mask_set_i | auto_mask_i;
      sw_q_o   <= (sw_q_o & ~sw_clr_i) | sw_set_i;
    end
  end
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/auto_mask_intc.sv
module auto_mask_intc
  import icu_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter logic [3:0]  DIE_ID  = 4'd0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        irq_line_i,
  input  logic [NUM_CPU-1:0]        bus_req_i,
  input  logic [NUM_CPU-1:0]        bus_we_i,
  input  logic [NUM_CPU*ADDR_W-1:0] bus_addr_i,
  input  logic [NUM_CPU*DATA_W-1:0] bus_wdata_i,
  output logic [NUM_CPU*DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CPU-1:0]        cpu_irq_o
);
  localparam int unsigned NUM_WORDS = NUM_IRQ / DATA_W;
  localparam int unsigned IDX_W     = $clog2(NUM_IRQ);
  localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_CPU-1:0][NUM_IRQ-1:0] dec_mset, dec_mclr, dec_sset, dec_sclr;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] route, elig;
  logic [NUM_CPU-1:0]              rd_en, ev_rd, top_valid, irq_q;
  reg_class_e                      rd_class [NUM_CPU];
  logic [NUM_CPU-1:0][3:0]         rd_word;
  logic [NUM_CPU-1:0][IDX_W-1:0]   top_idx;
  logic [NUM_CPU-1:0][DATA_W-1:0]  rdata_q;

  logic [NUM_IRQ-1:0] mask_set, mask_clr, sw_set, sw_clr, auto_mask;
  logic [NUM_IRQ-1:0] mask_q, sw_q, pend;
  logic [NUM_WORDS-1:0][DATA_W-1:0] mask_w, sw_w, pend_w;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
    icu_port_decode #(.NUM_IRQ(NUM_IRQ)) i_dec (
      .req_i      (bus_req_i[c]),
      .we_i       (bus_we_i[c]),
      .addr_i     (bus_addr_i[c*ADDR_W +: ADDR_W]),
      .wdata_i    (bus_wdata_i[c*DATA_W +: DATA_W]),
      .mask_set_o (dec_mset[c]),
      .mask_clr_o (dec_mclr[c]),
      .sw_set_o   (dec_sset[c]),
      .sw_clr_o   (dec_sclr[c]),
      .rd_en_o    (rd_en[c]),
      .ev_rd_o    (ev_rd[c]),
      .rd_class_o (rd_class[c]),
      .rd_word_o  (rd_word[c])
    );
  end

  always_comb begin
    mask_set  = '0;
    mask_clr  = '0;
    sw_set    = '0;
    sw_clr    = '0;
    auto_mask = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      mask_set |= dec_mset[c];
      mask_clr |= dec_mclr[c];
      sw_set   |= dec_sset[c];
      sw_clr   |= dec_sclr[c];
      if (ev_rd[c] && top_valid[c]) auto_mask[top_idx[c]] = 1'b1;
    end
  end

  icu_state #(.NUM_IRQ(NUM_IRQ)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_set_i  (mask_set),
    .mask_clr_i  (mask_clr),
    .auto_mask_i (auto_mask),
    .sw_set_i    (sw_set),
    .sw_clr_i    (sw_clr),
    .mask_q_o    (mask_q),
    .sw_q_o      (sw_q)
  );

  assign pend   = irq_line_i | sw_q;
  assign mask_w = mask_q;
  assign sw_w   = sw_q;
  assign pend_w = pend;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_route
      assign route[c][i] = ((i % NUM_CPU) == c);
    end

    assign elig[c] = pend & ~mask_q & route[c];

    icu_prio_enc #(.N(NUM_IRQ), .IDX_W(IDX_W)) i_prio (
      .req_i   (elig[c]),
      .valid_o (top_valid[c]),
      .idx_o   (top_idx[c])
    );

    event_t ev_word;
    always_comb begin
      ev_word = '0;
      if (top_valid[c]) begin
        ev_word.kind = EV_HW;
        ev_word.die  = DIE_ID;
        ev_word.num  = 16'(top_idx[c]);
      end
    end

    logic              word_ok;
    logic [WIDX_W-1:0] widx;
    assign word_ok = 32'(rd_word[c]) < NUM_WORDS;
    assign widx    = rd_word[c][WIDX_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_q[c] <= '0;
      end else if (rd_en[c]) begin
        unique case (rd_class[c])
          RC_MASK:  rdata_q[c] <= word_ok ? mask_w[widx] : '0;
          RC_SOFT:  rdata_q[c] <= word_ok ? sw_w[widx]   : '0;
          RC_PEND:  rdata_q[c] <= word_ok ? pend_w[widx] : '0;
          RC_EVENT: rdata_q[c] <= ev_word;
          default:  rdata_q[c] <= '0;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[c] <= 1'b0;
      else         irq_q[c] <= |elig[c];
    end

    assign bus_rdata_o[c*DATA_W +: DATA_W] = rdata_q[c];
  end

  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter logic [3:0]  DIE_ID  = 4'd0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_IRQ-1:0]   irq_line_i,
  input logic [NUM_CPU-1:0]   bus_req_i,
  input logic [NUM_CPU-1:0]   bus_we_i,
  input logic [NUM_CPU*8-1:0] bus_addr_i,
  input logic [NUM_CPU*32-1:0] bus_rdata_o,
  input logic [NUM_CPU-1:0]   cpu_irq_o,
  input logic [NUM_IRQ-1:0]   mask_q,
  input logic [NUM_IRQ-1:0]   sw_q
);
  localparam int unsigned IDX_W = $clog2(NUM_IRQ);

  function automatic logic [NUM_IRQ-1:0] below(input logic [IDX_W-1:0] n);
    for (int i = 0; i < NUM_IRQ; i++) below[i] = (i < int'(n));
  endfunction

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    logic [NUM_IRQ-1:0] elig_c, elig_q;
    logic               ev_q;
    logic [31:0]        rd;
    logic [IDX_W-1:0]   num;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_e
      assign elig_c[i] = (irq_line_i[i] | sw_q[i]) & ~mask_q[i] & ((i % NUM_CPU) == c);
    end

    assign rd  = bus_rdata_o[c*32 +: 32];
    assign num = rd[IDX_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ev_q   <= 1'b0;
        elig_q <= '0;
      end else begin
        ev_q   <= bus_req_i[c] && !bus_we_i[c] && (bus_addr_i[c*8+4 +: 4] == 4'd6);
        elig_q <= elig_c;
      end
    end

    AST_AUTO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q && rd[31:28] == 4'd1) |-> mask_q[num]); // R6
    AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q && rd[31:28] == 4'd1) |-> (((elig_q & below(num)) == '0) && elig_q[num])); // R5
    AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q && rd[31:28] == 4'd0) |-> (rd == 32'h0 && elig_q == '0)); // R7
    AST_EVENT_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q && rd[31:28] != 4'd0) |-> (rd[31:28] == 4'd1 && rd[27:24] == DIE_ID && rd[23:16] == 8'h0)); // R7
    AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_irq_o[c] == |elig_q); // R8
  end
endmodule

bind auto_mask_intc icu_checker #(
  .NUM_IRQ(NUM_IRQ),
  .NUM_CPU(NUM_CPU),
  .DIE_ID (DIE_ID)
) i_icu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_line_i  (irq_line_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .cpu_irq_o   (cpu_irq_o),
  .mask_q      (mask_q),
  .sw_q        (sw_q)
);

// File: tb/test_auto_mask_intc.sv
module test_auto_mask_intc;
  localparam int  CLK_PERIOD = 10;
  localparam int  NIRQ = 64;
  localparam int  NCPU = 2;
  localparam logic [3:0] DIE = 4'h5;

  typedef struct packed {
    logic [63:0] hw;
    logic [63:0] unmask;
    logic [31:0] ev0;
    logic [31:0] ev1;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{64'h60,                   64'hFFFF_FFFF_FFFF_FFFF, 32'h1500_0006, 32'h1500_0005},
    '{64'h0000_0102_0000_0004,  64'hFFFF_FFFF_FFFF_FFFB, 32'h1500_0028, 32'h1500_0021},
    '{64'h0,                    64'hFFFF_FFFF_FFFF_FFFF, 32'h0,         32'h0},
    '{64'hC000_0000_0000_0000,  64'hFFFF_FFFF_FFFF_FFFF, 32'h1500_003E, 32'h1500_003F},
    '{64'h1488,                 64'h1080,                32'h1500_000C, 32'h1500_0007},
    '{64'hFFFF_FFFF_FFFF_FFFF,  64'hFFFF_FFFF_FFFF_FFFF, 32'h1500_0000, 32'h1500_0001}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NIRQ-1:0]    irq_line = '0;
  logic [NCPU-1:0]    req = '0;
  logic [NCPU-1:0]    we = '0;
  logic [NCPU*8-1:0]  addr = '0;
  logic [NCPU*32-1:0] wdata = '0;
  logic [NCPU*32-1:0] rdata;
  logic [NCPU-1:0]    cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  auto_mask_intc #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .DIE_ID(DIE)) i_auto_mask_intc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_line_i  (irq_line),
    .bus_req_i   (req),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cpu_irq_o   (cpu_irq)
  );

  function automatic logic [31:0] ev(input int n);
    return {4'h1, DIE, 8'h0, 16'(n)};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req[p] = 1'b1; we[p] = 1'b1; addr[p*8 +: 8] = a; wdata[p*32 +: 32] = d;
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
  endtask

  task automatic rd(input int p, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req[p] = 1'b1; we[p] = 1'b0; addr[p*8 +: 8] = a;
    @(negedge clk);
    req[p] = 1'b0;
    d = rdata[p*32 +: 32];
  endtask

  task automatic mask_all();
    wr(0, 8'h00, 32'hFFFF_FFFF);
    wr(0, 8'h01, 32'hFFFF_FFFF);
    wr(0, 8'h30, 32'hFFFF_FFFF);
    wr(0, 8'h31, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq out", 32'(cpu_irq), 32'h0);
    rd(0, 8'h40, d); chk("R1 mask word0", d, 32'hFFFF_FFFF);
    rd(1, 8'h41, d); chk("R1 mask word1", d, 32'hFFFF_FFFF);
    rd(0, 8'h50, d); chk("R1 soft word0", d, 32'h0);
    rd(0, 8'h60, d); chk("R1 event none", d, 32'h0);

    // R5 R7 R10 vector table
    for (int v = 0; v < NVEC; v++) begin
      mask_all();
      irq_line = VECS[v].hw;
      wr(0, 8'h10, VECS[v].unmask[31:0]);
      wr(1, 8'h11, VECS[v].unmask[63:32]);
      rd(0, 8'h60, d); chk($sformatf("R5 vec%0d cpu0", v), d, VECS[v].ev0);
      rd(1, 8'h60, d); chk($sformatf("R5 vec%0d cpu1", v), d, VECS[v].ev1);
    end

    // R6 auto-mask, R2 level
    mask_all();
    irq_line = 64'h10;
    wr(0, 8'h10, 32'h10);
    rd(0, 8'h60, d); chk("R6 first delivery", d, ev(4));
    rd(0, 8'h40, d); chk("R6 mask bit set", 32'(d[4]), 32'h1);
    rd(0, 8'h60, d); chk("R6 no redelivery", d, 32'h0);
    wr(0, 8'h10, 32'h10);
    rd(0, 8'h60, d); chk("R2 line still high", d, ev(4));
    wr(0, 8'h10, 32'h10);
    irq_line = '0;
    rd(0, 8'h60, d); chk("R2 line dropped", d, 32'h0);

    // R3 software trigger
    mask_all();
    wr(1, 8'h20, 32'h200);
    rd(1, 8'h50, d); chk("R3 soft readback", d, 32'h200);
    rd(0, 8'h70, d); chk("R10 pending word", d, 32'h200);
    wr(1, 8'h10, 32'h200);
    rd(1, 8'h60, d); chk("R3 soft event", d, ev(9));
    wr(1, 8'h30, 32'h200);
    rd(1, 8'h50, d); chk("R3 soft cleared", d, 32'h0);
    wr(1, 8'h10, 32'h200);
    rd(1, 8'h60, d); chk("R3 no event after clear", d, 32'h0);

    // R4 zero bits ignored, masked line silent
    mask_all();
    wr(0, 8'h11, 32'h0000_FFFF);
    wr(0, 8'h01, 32'h0);
    wr(1, 8'h11, 32'h0);
    rd(0, 8'h41, d); chk("R4 zero bits no effect", d, 32'hFFFF_0000);
    irq_line = 64'h0004_0000_0000_0000;
    repeat (2) @(negedge clk);
    chk("R4 masked no irq", 32'(cpu_irq), 32'h0);
    rd(0, 8'h60, d); chk("R4 masked no event", d, 32'h0);
    irq_line = '0;

    // R8 output lag
    mask_all();
    wr(0, 8'h10, 32'h100);
    irq_line[8] = 1'b1;
    #1 chk("R8 not yet high", 32'(cpu_irq[0]), 32'h0);
    @(negedge clk); chk("R8 high after one edge", 32'(cpu_irq[0]), 32'h1);
    wr(0, 8'h00, 32'h100);
    chk("R8 still high at mask edge", 32'(cpu_irq[0]), 32'h1);
    @(negedge clk); chk("R8 low after one edge", 32'(cpu_irq[0]), 32'h0);
    irq_line = '0;

    // R9 same-cycle auto-mask vs mask-clear
    mask_all();
    irq_line = 64'h10_0000;
    wr(0, 8'h10, 32'h10_0000);
    @(negedge clk);
    req = 2'b11; we = 2'b10;
    addr[7:0] = 8'h60; addr[15:8] = 8'h10; wdata[63:32] = 32'h10_0000;
    @(negedge clk);
    req = '0; we = '0;
    chk("R9 delivered", rdata[31:0], ev(20));
    rd(1, 8'h40, d); chk("R9 stays masked", 32'(d[20]), 32'h1);
    rd(0, 8'h60, d); chk("R9 no redelivery", d, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule